// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates eight interrupt request lines for one processor interrupt input. It captures each line either on a rising edge or as a level, and tracks three 8-bit states: pending requests, a mask, and the lines currently in service. A stored rotation offset sets where the priority scan begins. The block raises its pending output only when the best unmasked request outranks everything already in service. It also reports that request's line number.

The processor side acknowledges the chosen interrupt with a one-cycle strobe. It retires interrupts with end-of-interrupt commands, given as a 3-bit code plus a line operand. Automatic end-of-interrupt, rotation on automatic end-of-interrupt, and exclusion of the cascade input from the in-service comparison are all static mode inputs. The per-line trigger select arrives as a register value from outside the block. Bus decoding and vector formation belong to the surrounding logic.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset the request, mask and in-service states and the rotation offset are all zero, and `irq_o` is low.
- R2: A line whose `lvl_sel_i` bit is 0 sets its request bit on the clock after a low-to-high change, judged against the line value sampled one clock earlier. A line held high sets nothing further once its request bit has been cleared.
- R3: A line whose `lvl_sel_i` bit is 1 has its request bit copy the line on every clock. An acknowledge does not clear that bit.
- R4: Eligible lines are those with the request bit set and the mask bit clear. Priority rank of line L is (L - offset) mod 8, and rank 0 is the highest. `irq_num_o` gives the line of the best-ranked eligible request.
- R5: `irq_o` is high only when the best eligible rank is strictly lower than the best rank in service. With nothing eligible, `irq_o` is low.
- R6: With `nest_i` high, line 2 (the cascade input) is left out of the in-service rank used by R5.
- R7: When `ack_i` is high and `irq_o` is high, the winning line's in-service bit is set unless `auto_eoi_i` is high. Its request bit is cleared if the line is edge triggered, unless a new rising edge arrives in the same cycle. When `irq_o` is low, `ack_i` has no effect.
- R8: When an acknowledge is taken with `auto_eoi_i` and `auto_rot_i` both high, the offset becomes (line + 1) mod 8.
- R9: `cmd_i` = 1 clears the best-ranked in-service bit. `cmd_i` = 2 does the same and also sets the offset to (that line + 1) mod 8. Both do nothing when no bit is in service.
- R10: `cmd_i` = 3 clears the in-service bit of `cmd_line_i`. `cmd_i` = 4 clears it and sets the offset to (`cmd_line_i` + 1) mod 8. `cmd_i` = 5 only sets that offset. `cmd_i` = 0, 6 and 7 do nothing.
- R11: When `mask_we_i` is high, the mask register loads `mask_i` on that clock. A set mask bit makes its line ineligible.
- R12: When a command and a taken acknowledge fall in the same cycle, the command's clear is applied before the acknowledge's set, and a command that changes the offset overrides automatic rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 8 | Interrupt request lines |
| lvl_sel_i | input | 8 | Per-line trigger select, 1 = level |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | 8 | Mask value to write |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt mode |
| auto_rot_i | input | 1 | Rotate on automatic end-of-interrupt |
| nest_i | input | 1 | Leave the cascade line out of the in-service rank |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| cmd_i | input | 3 | End-of-interrupt / priority command code |
| cmd_line_i | input | 3 | Line operand for commands 3, 4 and 5 |
| irq_o | output | 1 | Interrupt pending to the processor |
| irq_num_o | output | 3 | Winning line number, valid while irq_o is high |

## Verification
A wrong state has limited visibility at the ports. A lost or stale request bit, or a stale in-service bit, shows up only through `irq_o` and `irq_num_o`, so it appears on the first clock after the state that triggers it. A wrong offset stays hidden until two or more lines compete, when `irq_num_o` names the wrong winner. An in-service bit that was never cleared shows up as a missing interrupt after a lower-ranked line is raised. The bench therefore runs a behavioural model in lock step and compares both outputs every cycle. It mixes the directed sequences with random multi-line traffic, so offset and in-service errors meet competing requests soon after they occur.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE        = 3'd0,
    CMD_EOI_TOP     = 3'd1,
    CMD_EOI_TOP_ROT = 3'd2,
    CMD_EOI_AT      = 3'd3,
    CMD_EOI_AT_ROT  = 3'd4,
    CMD_SET_LOW     = 3'd5
  } cmd_e;
endpackage

// File: rtl/prio_scan.sv
// Rotated first-set scan: rank k examines line (offs + k) mod N.
module prio_scan #(
  parameter int N  = 8,
  localparam int LW = $clog2(N),
  localparam int PW = LW + 1
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] offs_i,
  output logic [PW-1:0] prio_o,
  output logic [LW-1:0] line_o
);
  always_comb begin
    prio_o = PW'(N);
    line_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec_i[LW'(offs_i + LW'(k))]) begin
        prio_o = PW'(k);
        line_o = LW'(offs_i + LW'(k));
      end
    end
  end
endmodule

// File: rtl/prio_req_capture.sv
module prio_req_capture #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] lvl_sel_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] last_q;
  logic [N-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= line_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           req_q[g] <= 1'b0;
      else if (lvl_sel_i[g]) req_q[g] <= line_i[g];
      else                   req_q[g] <= (req_q[g] & ~clr_i[g]) | (line_i[g] & ~last_q[g]);
    end

    assert_level_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_sel_i[g] |=> req_q[g] == $past(line_i[g]));
    assert_edge_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_sel_i[g] && line_i[g] && !last_q[g]) |=> req_q[g]);
    assert_no_edge_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_sel_i[g] && !req_q[g] && !(line_i[g] && !last_q[g])) |=> !req_q[g]);
    assert_ack_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_sel_i[g] && clr_i[g] && !(line_i[g] && !last_q[g])) |=> !req_q[g]);
  end

  assign req_o = req_q;
endmodule

// File: rtl/prio_svc_ctrl.sv
// In-service, mask and rotation offset state.
module prio_svc_ctrl import prio_irq_pkg::*; #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [LW-1:0] win_i,
  input  logic          auto_eoi_i,
  input  logic          auto_rot_i,
  input  cmd_e          cmd_i,
  input  logic [LW-1:0] cmd_line_i,
  input  logic          eoi_hit_i,
  input  logic [LW-1:0] eoi_line_i,
  input  logic          mask_we_i,
  input  logic [N-1:0]  mask_i,
  output logic [N-1:0]  isr_o,
  output logic [N-1:0]  imr_o,
  output logic [LW-1:0] offs_o
);
  logic [N-1:0]  isr_q, imr_q, clr, set;
  logic [LW-1:0] offs_q, offs_d;

  always_comb begin
    clr = '0;
    unique case (cmd_i)
      CMD_EOI_TOP, CMD_EOI_TOP_ROT: if (eoi_hit_i) clr[eoi_line_i] = 1'b1;
      CMD_EOI_AT, CMD_EOI_AT_ROT:   clr[cmd_line_i] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    set = '0;
    if (take_i && !auto_eoi_i) set[win_i] = 1'b1;
  end

  // command-driven rotation overrides automatic rotation
  always_comb begin
    offs_d = offs_q;
    if (cmd_i == CMD_EOI_TOP_ROT && eoi_hit_i)
      offs_d = eoi_line_i + LW'(1);
    else if (cmd_i == CMD_EOI_AT_ROT || cmd_i == CMD_SET_LOW)
      offs_d = cmd_line_i + LW'(1);
    else if (take_i && auto_eoi_i && auto_rot_i)
      offs_d = win_i + LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q  <= '0;
      imr_q  <= '0;
      offs_q <= '0;
    end else begin
      isr_q  <= (isr_q & ~clr) | set;
      offs_q <= offs_d;
      if (mask_we_i) imr_q <= mask_i;
    end
  end

  assign isr_o  = isr_q;
  assign imr_o  = imr_q;
  assign offs_o = offs_q;

  assert_ack_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !auto_eoi_i) |=> isr_q[$past(win_i)]);
  assert_aeoi_no_mark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && auto_eoi_i && !isr_q[win_i]) |=> !isr_q[$past(win_i)]);
  assert_aeoi_rotate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && auto_eoi_i && auto_rot_i && cmd_i == CMD_NONE) |=> offs_q == LW'($past(win_i) + 1));
  assert_spec_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_EOI_AT && !(take_i && !auto_eoi_i && win_i == cmd_line_i))
      |=> !isr_q[$past(cmd_line_i)]);
  assert_set_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_SET_LOW) |=> offs_q == LW'($past(cmd_line_i) + 1));
  assert_top_rot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_EOI_TOP_ROT && eoi_hit_i) |=> offs_q == LW'($past(eoi_line_i) + 1));
  assert_ack_over_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !auto_eoi_i && cmd_i == CMD_EOI_AT && cmd_line_i == win_i) |=> isr_q[$past(win_i)]);
  assert_mask_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> imr_q == $past(mask_i));
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver import prio_irq_pkg::*; #(
  parameter int N_LINES   = 8,
  parameter int CASC_LINE = 2,
  parameter bit IS_MASTER = 1'b1,
  localparam int LW = $clog2(N_LINES),
  localparam int PW = LW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic [N_LINES-1:0] lvl_sel_i,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               auto_eoi_i,
  input  logic               auto_rot_i,
  input  logic               nest_i,
  input  logic               ack_i,
  input  logic [2:0]         cmd_i,
  input  logic [LW-1:0]      cmd_line_i,
  output logic               irq_o,
  output logic [LW-1:0]      irq_num_o
);
  logic [N_LINES-1:0] req, isr, imr, elig, isr_cmp, ack_clr;
  logic [LW-1:0]      offs, win_line, cur_line, eoi_line;
  logic [PW-1:0]      win_prio, cur_prio, eoi_prio;
  logic               take, eoi_hit;
  cmd_e               cmd;

  assign cmd  = cmd_e'(cmd_i);
  assign elig = req & ~imr;

  if (IS_MASTER) begin : g_master
    always_comb begin
      isr_cmp = isr;
      if (nest_i) isr_cmp[CASC_LINE] = 1'b0;
    end
  end else begin : g_slave
    assign isr_cmp = isr;
  end

  prio_scan #(.N(N_LINES)) u_scan_req (
    .vec_i(elig), .offs_i(offs), .prio_o(win_prio), .line_o(win_line));
  prio_scan #(.N(N_LINES)) u_scan_cur (
    .vec_i(isr_cmp), .offs_i(offs), .prio_o(cur_prio), .line_o(cur_line));
  prio_scan #(.N(N_LINES)) u_scan_eoi (
    .vec_i(isr), .offs_i(offs), .prio_o(eoi_prio), .line_o(eoi_line));

  assign irq_o     = win_prio < cur_prio;
  assign irq_num_o = win_line;
  assign take      = ack_i & irq_o;
  assign eoi_hit   = eoi_prio != PW'(N_LINES);

  always_comb begin
    ack_clr = '0;
    if (take && !lvl_sel_i[win_line]) ack_clr[win_line] = 1'b1;
  end

  prio_req_capture #(.N(N_LINES)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .lvl_sel_i(lvl_sel_i),
    .clr_i(ack_clr), .req_o(req));

  prio_svc_ctrl #(.N(N_LINES)) u_svc (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .win_i(win_line),
    .auto_eoi_i(auto_eoi_i), .auto_rot_i(auto_rot_i), .cmd_i(cmd),
    .cmd_line_i(cmd_line_i), .eoi_hit_i(eoi_hit), .eoi_line_i(eoi_line),
    .mask_we_i(mask_we_i), .mask_i(mask_i), .isr_o(isr), .imr_o(imr),
    .offs_o(offs));

  assert_win_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req[irq_num_o] && !imr[irq_num_o]));
  assert_cur_in_service_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prio != PW'(N_LINES)) |-> isr_cmp[cur_line]);
  assert_win_not_serviced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(IS_MASTER && nest_i && irq_num_o == LW'(CASC_LINE))) |-> !isr[irq_num_o]);
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig == '0) |-> !irq_o);
  assert_cascade_nest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_MASTER && nest_i && isr == N_LINES'(1 << CASC_LINE) && elig[CASC_LINE]) |-> irq_o);
endmodule

// File: tb/tb_prio_irq_resolver.sv
module tb_prio_irq_resolver;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] line_i = '0, lvl_sel_i = '0, mask_i = '0;
  logic       mask_we_i = 1'b0, auto_eoi_i = 1'b0, auto_rot_i = 1'b0, nest_i = 1'b0, ack_i = 1'b0;
  logic [2:0] cmd_i = '0, cmd_line_i = '0;
  logic       irq_o;
  logic [2:0] irq_num_o;

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string tag = "R1";

  always #(CLK_P / 2) clk = ~clk;

  prio_irq_resolver dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i), .lvl_sel_i(lvl_sel_i),
    .mask_we_i(mask_we_i), .mask_i(mask_i), .auto_eoi_i(auto_eoi_i),
    .auto_rot_i(auto_rot_i), .nest_i(nest_i), .ack_i(ack_i), .cmd_i(cmd_i),
    .cmd_line_i(cmd_line_i), .irq_o(irq_o), .irq_num_o(irq_num_o));

  // behavioural reference
  bit [7:0] m_irr, m_imr, m_isr, m_last;
  int       m_offs;

  function automatic int m_rank(bit [7:0] v, int off);
    for (int k = 0; k < 8; k++) if (v[(k + off) % 8]) return k;
    return 8;
  endfunction

  function automatic void m_out(output bit p, output int n);
    bit [7:0] iv;
    int pr, cp;
    pr = m_rank(m_irr & ~m_imr, m_offs);
    iv = m_isr;
    if (nest_i) iv[2] = 1'b0;
    cp = m_rank(iv, m_offs);
    p  = pr < cp;
    n  = (pr + m_offs) % 8;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_irr = '0; m_imr = '0; m_isr = '0; m_last = '0; m_offs = 0;
    end else begin
      bit p, take, off_set;
      int n, h, ln, cl, noffs;
      bit [7:0] nirr, nisr;
      m_out(p, n);
      take = ack_i && p;
      cl   = int'(cmd_line_i);
      for (int i = 0; i < 8; i++) begin
        if (lvl_sel_i[i]) nirr[i] = line_i[i];
        else begin
          nirr[i] = m_irr[i];
          if (take && n == i) nirr[i] = 1'b0;
          if (line_i[i] && !m_last[i]) nirr[i] = 1'b1;
        end
      end
      nisr = m_isr; noffs = m_offs; off_set = 1'b0;
      if (cmd_i == 3'd1 || cmd_i == 3'd2) begin
        h = m_rank(m_isr, m_offs);
        if (h < 8) begin
          ln = (h + m_offs) % 8;
          nisr[ln] = 1'b0;
          if (cmd_i == 3'd2) begin noffs = (ln + 1) % 8; off_set = 1'b1; end
        end
      end else if (cmd_i == 3'd3) nisr[cl] = 1'b0;
      else if (cmd_i == 3'd4) begin nisr[cl] = 1'b0; noffs = (cl + 1) % 8; off_set = 1'b1; end
      else if (cmd_i == 3'd5) begin noffs = (cl + 1) % 8; off_set = 1'b1; end
      if (take) begin
        if (!auto_eoi_i) nisr[n] = 1'b1;
        else if (auto_rot_i && !off_set) noffs = (n + 1) % 8;
      end
      if (mask_we_i) m_imr = mask_i;
      m_irr = nirr; m_isr = nisr; m_offs = noffs; m_last = line_i;
    end
  end

  // lock-step comparison, sampled after the edge has settled
  always @(posedge clk) begin
    #(CLK_P / 4);
    if (rst_ni && !done) begin
      bit p; int n;
      m_out(p, n);
      checks++;
      if (irq_o !== p || (p && int'(irq_num_o) != n)) begin
        fails++;
        $display("FAIL %s model: irq=%0b num=%0d expected irq=%0b num=%0d", tag, irq_o, irq_num_o, p, n);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string r, bit ep, int en);
    checks++;
    if (irq_o !== ep || (ep && int'(irq_num_o) != en)) begin
      fails++;
      $display("FAIL %s: irq=%0b num=%0d expected irq=%0b num=%0d", r, irq_o, irq_num_o, ep, en);
    end
  endtask

  task automatic cmd(int c, int l);
    cmd_i = 3'(c); cmd_line_i = 3'(l);
    step();
    cmd_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    step();
    ack_i = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_P * 60000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    chk("R1", 0, 0);

    tag = "R2";
    line_i = 8'h20; step(); chk("R2", 1, 5);
    ack(); chk("R7", 0, 0);
    cmd(1, 0); chk("R2", 0, 0);
    line_i = '0; step();

    tag = "R3";
    lvl_sel_i = 8'h08; line_i = 8'h08; step(); chk("R3", 1, 3);
    ack(); chk("R5", 0, 0);
    cmd(3, 3); chk("R3", 1, 3);
    ack();
    line_i = '0; step(); chk("R3", 0, 0);
    cmd(1, 0); chk("R3", 0, 0);
    lvl_sel_i = '0;

    tag = "R5";
    line_i = 8'h10; step();
    ack();
    line_i = 8'h50; step(); chk("R5", 0, 0);
    line_i = 8'h52; step(); chk("R5", 1, 1);
    tag = "R11";
    mask_we_i = 1'b1; mask_i = 8'h02; step(); mask_we_i = 1'b0; chk("R11", 0, 0);
    tag = "R9";
    cmd(1, 0); chk("R9", 1, 6);
    tag = "R4";
    mask_we_i = 1'b1; mask_i = 8'h00; step(); mask_we_i = 1'b0; chk("R4", 1, 1);

    tag = "R10";
    cmd(5, 4); chk("R10", 1, 6);
    ack(); chk("R5", 0, 0);
    cmd(4, 6); chk("R10", 1, 1);
    ack();
    line_i = '0; step();
    tag = "R9";
    cmd(2, 0); chk("R9", 0, 0);
    line_i = 8'h06; step(); chk("R9", 1, 2);
    ack(); cmd(1, 0); ack(); cmd(1, 0);
    line_i = '0; step();

    tag = "R8";
    auto_eoi_i = 1'b1; auto_rot_i = 1'b1;
    line_i = 8'h08; step(); chk("R8", 1, 3);
    ack(); chk("R8", 0, 0);
    line_i = '0; step();
    line_i = 8'h28; step(); chk("R8", 1, 5);
    ack(); chk("R8", 1, 3);
    ack(); chk("R8", 0, 0);
    auto_eoi_i = 1'b0; auto_rot_i = 1'b0;

    tag = "R6";
    line_i = '0; step();
    line_i = 8'h04; step(); chk("R6", 1, 2);
    ack();
    line_i = '0; step();
    line_i = 8'h04; nest_i = 1'b1; step(); chk("R6", 1, 2);
    nest_i = 1'b0; step(); chk("R6", 0, 0);
    cmd(1, 0); ack(); cmd(1, 0);
    line_i = '0; step();

    tag = "R12";
    line_i = 8'h80; step(); chk("R12", 1, 7);
    ack_i = 1'b1; cmd(3, 7); ack_i = 1'b0;
    line_i = 8'h81; step(); chk("R12", 0, 0);
    cmd(1, 0); chk("R12", 1, 0);
    ack(); cmd(1, 0);
    line_i = '0; step();

    tag = "R4";
    for (int c = 0; c < 4000; c++) begin
      line_i     = 8'($urandom);
      ack_i      = ($urandom % 3) == 0;
      cmd_i      = (($urandom % 4) == 0) ? 3'($urandom) : 3'd0;
      cmd_line_i = 3'($urandom);
      mask_we_i  = ($urandom % 8) == 0;
      mask_i     = 8'($urandom) & 8'($urandom);
      if (($urandom % 32) == 0) lvl_sel_i = 8'($urandom);
      if (($urandom % 32) == 0) begin
        auto_eoi_i = 1'($urandom); auto_rot_i = 1'($urandom); nest_i = 1'($urandom);
      end
      if (c == 2000) tag = "R12";
      step();
    end
    ack_i = 1'b0; cmd_i = '0; mask_we_i = 1'b0;
    step(); step();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule